// File: doc/BRIEF.md
# Single-Trip Delay Calibration Controller

This block lives in the receive side of a serial-link slave. It holds the variable delay of one downlink hop, measured from the upstream transmitter's synchronization point to this receiver's synchronization point, close to a programmed target. It builds the current hop delay from three terms: the upstream transmit-path delay, the local receive-path delay, and the phase offset the block has already applied. The block compares that sum with the target and moves the receive core clock phase by single steps through a dynamic phase-shift handshake.

The upstream delay comes from one of two places. The first is a word captured from the incoming hyperframe at a programmable basic-frame and word position. The second is a value that software writes. A consistency check runs when software requests one. It can also run automatically at every hyperframe boundary. Each accepted check publishes the measured delay in the same whole-cycle plus fractional-step format as the target. While calibration is enabled, each check may issue one phase step. The total applied offset is bounded by programmable limits.

Top module: `trip_delay_cal`

## Requirements
- R1: When `cal_en_i` is low an accepted check issues no phase step and leaves the offset unchanged, but it still updates the published measurement.
- R2: The target in steps is `tgt_cyc_i * STEPS_PER_CYCLE + tgt_step_i`. A check whose measurement equals this value issues no step.
- R3: A check is requested by a one-cycle `chk_req_i` pulse, or by `hf_start_i` while `auto_chk_i` is high. `hf_start_i` has no effect while `auto_chk_i` is low.
- R4: The measurement in steps is upstream delay + `rx_path_dly_i` + offset, clamped at zero. It is captured at the clock edge that accepts the check and is published as `cur_cyc_o` (quotient by STEPS_PER_CYCLE) and `cur_step_o` (remainder).
- R5: With `up_from_reg_i` high, the upstream delay is `up_reg_dly_i`. With it low, it is the last `rx_word_i` latched while `rx_vld_i` was high and `bf_cnt_i`/`wd_cnt_i` equalled `up_loc_bf_i`/`up_loc_wd_i`. Words at any other position, or without `rx_vld_i`, are ignored.
- R6: An enabled check issues at most one step. When the target exceeds the measurement, it issues a step with `ps_dir_o`=1 and the offset rises by 1. When the target is below the measurement, it issues a step with `ps_dir_o`=0 and the offset falls by 1. Between steps the offset does not change.
- R7: `ps_step_o` is a one-cycle pulse in the cycle after the accepting edge. `busy_o` rises with it and falls at the edge that samples `ps_done_i` high. Checks requested while busy are ignored and do not update the status.
- R8: The offset never rises above `ofs_max_i` or falls below `ofs_min_i`. A check that needs a step beyond a limit issues none and sets `oor_o`, which then stays high until reset.
- R9: Reset clears the offset, `busy_o`, `oor_o`, the published measurement and the latched hyperframe value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_en_i | input | 1 | Calibration enable |
| auto_chk_i | input | 1 | Run a check at every hyperframe boundary |
| chk_req_i | input | 1 | Software check request pulse |
| hf_start_i | input | 1 | Hyperframe boundary pulse from the deframer |
| tgt_cyc_i | input | CYC_W | Target, whole cycles |
| tgt_step_i | input | STEP_W | Target, fractional steps |
| up_from_reg_i | input | 1 | 1: upstream delay from register, 0: from hyperframe |
| up_reg_dly_i | input | DLY_W | Software-written upstream delay, in steps |
| up_loc_bf_i | input | BF_W | Basic-frame index of the upstream delay word |
| up_loc_wd_i | input | WD_W | Word index of the upstream delay word |
| bf_cnt_i | input | BF_W | Deframer basic-frame counter |
| wd_cnt_i | input | WD_W | Deframer word counter |
| rx_vld_i | input | 1 | Received word valid |
| rx_word_i | input | DLY_W | Received word |
| rx_path_dly_i | input | DLY_W | Local receive-path delay without offset, in steps |
| ofs_min_i | input | OFS_W | Lowest allowed offset (signed) |
| ofs_max_i | input | OFS_W | Highest allowed offset (signed) |
| ps_done_i | input | 1 | Phase-shift completion pulse |
| ps_step_o | output | 1 | Phase-shift step pulse |
| ps_dir_o | output | 1 | Step direction, 1 = more delay |
| busy_o | output | 1 | Waiting for phase-shift completion |
| cur_cyc_o | output | CYC_W | Measured delay, whole cycles |
| cur_step_o | output | STEP_W | Measured delay, fractional steps |
| ofs_o | output | OFS_W | Applied phase offset in steps (signed) |
| oor_o | output | 1 | Sticky out-of-range flag |

## Verification
The bench builds the block with STEPS_PER_CYCLE=8, CYC_W=6 and OFS_W=6, so the delay is held in 9 bits. Because of this, both the cycle and the step fields of measurements in the 20 to 40 step range carry nonzero values. Offset limits programmed at -2 and +3 let a few checks walk the offset into both limits, which exercises blocked steps and the sticky flag. The hyperframe position is set to basic frame 5, word 2. Decoy words are sent one index away on each counter and at the right position without valid.

// File: rtl/trip_cal_pkg.sv
package trip_cal_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_UP    = 2'd1,
    ACT_DN    = 2'd2,
    ACT_BLOCK = 2'd3
  } cal_act_e;
endpackage

// File: rtl/trip_cal_upstream.sv
module trip_cal_upstream #(
  parameter int DLY_W = 12,
  parameter int BF_W  = 8,
  parameter int WD_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_reg_i,
  input  logic [DLY_W-1:0] reg_dly_i,
  input  logic [BF_W-1:0]  loc_bf_i,
  input  logic [WD_W-1:0]  loc_wd_i,
  input  logic [BF_W-1:0]  bf_cnt_i,
  input  logic [WD_W-1:0]  wd_cnt_i,
  input  logic             rx_vld_i,
  input  logic [DLY_W-1:0] rx_word_i,
  output logic [DLY_W-1:0] up_dly_o
);
  logic [DLY_W-1:0] hf_q;
  logic             hit;

  assign hit = rx_vld_i && (bf_cnt_i == loc_bf_i) && (wd_cnt_i == loc_wd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  hf_q <= '0;
    else if (hit) hf_q <= rx_word_i;
  end

  assign up_dly_o = src_reg_i ? reg_dly_i : hf_q;
endmodule

// File: rtl/trip_cal_measure.sv
module trip_cal_measure #(
  parameter int CYC_W           = 8,
  parameter int STEPS_PER_CYCLE = 16,
  parameter int OFS_W           = 8,
  localparam int STEP_W         = $clog2(STEPS_PER_CYCLE),
  localparam int DLY_W          = CYC_W + STEP_W
) (
  input  logic                    [DLY_W-1:0]  up_dly_i,
  input  logic                    [DLY_W-1:0]  rx_dly_i,
  input  logic signed             [OFS_W-1:0]  ofs_i,
  input  logic                    [CYC_W-1:0]  tgt_cyc_i,
  input  logic                    [STEP_W-1:0] tgt_step_i,
  output logic                    [CYC_W-1:0]  meas_cyc_o,
  output logic                    [STEP_W-1:0] meas_step_o,
  output logic                                 gt_o,
  output logic                                 lt_o
);
  localparam int SUM_W = ((DLY_W > OFS_W) ? DLY_W : OFS_W) + 2;
  localparam int TGT_W = DLY_W + 1;
  localparam logic [DLY_W-1:0] MEAS_MAX = DLY_W'((2 ** CYC_W) * STEPS_PER_CYCLE - 1);
  localparam bit SPC_POW2 = (STEPS_PER_CYCLE & (STEPS_PER_CYCLE - 1)) == 0;

  logic signed [SUM_W-1:0] ofs_x, sum_s, max_s;
  logic        [DLY_W-1:0] meas;
  logic        [TGT_W-1:0] tgt_lin;

  assign ofs_x = SUM_W'(ofs_i);
  assign max_s = $signed(SUM_W'(MEAS_MAX));
  assign sum_s = $signed(SUM_W'(up_dly_i)) + $signed(SUM_W'(rx_dly_i)) + ofs_x;

  always_comb begin
    if (sum_s < 0)          meas = '0;
    else if (sum_s > max_s) meas = MEAS_MAX;
    else                    meas = sum_s[DLY_W-1:0];
  end

  assign tgt_lin = TGT_W'(tgt_cyc_i) * TGT_W'(STEPS_PER_CYCLE) + TGT_W'(tgt_step_i);
  assign gt_o    = tgt_lin > {1'b0, meas};
  assign lt_o    = tgt_lin < {1'b0, meas};

  generate
    if (SPC_POW2) begin : g_shift
      assign meas_cyc_o  = meas[DLY_W-1:STEP_W];
      assign meas_step_o = meas[STEP_W-1:0];
    end else begin : g_div
      assign meas_cyc_o  = CYC_W'(meas / DLY_W'(STEPS_PER_CYCLE));
      assign meas_step_o = STEP_W'(meas % DLY_W'(STEPS_PER_CYCLE));
    end
  endgenerate
endmodule

// File: rtl/trip_cal_stepper.sv
module trip_cal_stepper
  import trip_cal_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    chk_i,
  input  logic                    en_i,
  input  logic                    gt_i,
  input  logic                    lt_i,
  input  logic signed [OFS_W-1:0] ofs_min_i,
  input  logic signed [OFS_W-1:0] ofs_max_i,
  input  logic                    ps_done_i,
  output logic                    accept_o,
  output logic                    ps_step_o,
  output logic                    ps_dir_o,
  output logic                    busy_o,
  output logic signed [OFS_W-1:0] ofs_o,
  output logic                    oor_o
);
  localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

  cal_act_e                act;
  logic                    step_q, dir_q, busy_q, oor_q;
  logic signed [OFS_W-1:0] ofs_q;

  assign accept_o = chk_i && !busy_q;

  always_comb begin
    act = ACT_NONE;
    if (en_i && gt_i)      act = (ofs_q >= ofs_max_i) ? ACT_BLOCK : ACT_UP;
    else if (en_i && lt_i) act = (ofs_q <= ofs_min_i) ? ACT_BLOCK : ACT_DN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      oor_q  <= 1'b0;
      ofs_q  <= '0;
    end else begin
      step_q <= 1'b0;
      if (accept_o) begin
        unique case (act)
          ACT_UP: begin
            step_q <= 1'b1;
            dir_q  <= 1'b1;
            busy_q <= 1'b1;
            ofs_q  <= ofs_q + ONE;
          end
          ACT_DN: begin
            step_q <= 1'b1;
            dir_q  <= 1'b0;
            busy_q <= 1'b1;
            ofs_q  <= ofs_q - ONE;
          end
          ACT_BLOCK: oor_q <= 1'b1;
          default: ;
        endcase
      end else if (busy_q && ps_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign ps_step_o = step_q;
  assign ps_dir_o  = dir_q;
  assign busy_o    = busy_q;
  assign ofs_o     = ofs_q;
  assign oor_o     = oor_q;
endmodule

// File: rtl/trip_delay_cal.sv
module trip_delay_cal #(
  parameter int CYC_W           = 8,
  parameter int STEPS_PER_CYCLE = 16,
  parameter int OFS_W           = 8,
  parameter int BF_W            = 8,
  parameter int WD_W            = 4,
  localparam int STEP_W         = $clog2(STEPS_PER_CYCLE),
  localparam int DLY_W          = CYC_W + STEP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cal_en_i,
  input  logic                    auto_chk_i,
  input  logic                    chk_req_i,
  input  logic                    hf_start_i,
  input  logic [CYC_W-1:0]        tgt_cyc_i,
  input  logic [STEP_W-1:0]       tgt_step_i,
  input  logic                    up_from_reg_i,
  input  logic [DLY_W-1:0]        up_reg_dly_i,
  input  logic [BF_W-1:0]         up_loc_bf_i,
  input  logic [WD_W-1:0]         up_loc_wd_i,
  input  logic [BF_W-1:0]         bf_cnt_i,
  input  logic [WD_W-1:0]         wd_cnt_i,
  input  logic                    rx_vld_i,
  input  logic [DLY_W-1:0]        rx_word_i,
  input  logic [DLY_W-1:0]        rx_path_dly_i,
  input  logic signed [OFS_W-1:0] ofs_min_i,
  input  logic signed [OFS_W-1:0] ofs_max_i,
  input  logic                    ps_done_i,
  output logic                    ps_step_o,
  output logic                    ps_dir_o,
  output logic                    busy_o,
  output logic [CYC_W-1:0]        cur_cyc_o,
  output logic [STEP_W-1:0]       cur_step_o,
  output logic signed [OFS_W-1:0] ofs_o,
  output logic                    oor_o
);
  logic [DLY_W-1:0]  up_dly;
  logic [CYC_W-1:0]  meas_cyc, cyc_q;
  logic [STEP_W-1:0] meas_step, stp_q;
  logic              gt, lt, chk, accept;

  assign chk = chk_req_i || (auto_chk_i && hf_start_i);

  trip_cal_upstream #(.DLY_W(DLY_W), .BF_W(BF_W), .WD_W(WD_W)) i_upstream (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_reg_i (up_from_reg_i),
    .reg_dly_i (up_reg_dly_i),
    .loc_bf_i  (up_loc_bf_i),
    .loc_wd_i  (up_loc_wd_i),
    .bf_cnt_i  (bf_cnt_i),
    .wd_cnt_i  (wd_cnt_i),
    .rx_vld_i  (rx_vld_i),
    .rx_word_i (rx_word_i),
    .up_dly_o  (up_dly)
  );

  trip_cal_measure #(.CYC_W(CYC_W), .STEPS_PER_CYCLE(STEPS_PER_CYCLE), .OFS_W(OFS_W)) i_measure (
    .up_dly_i    (up_dly),
    .rx_dly_i    (rx_path_dly_i),
    .ofs_i       (ofs_o),
    .tgt_cyc_i   (tgt_cyc_i),
    .tgt_step_i  (tgt_step_i),
    .meas_cyc_o  (meas_cyc),
    .meas_step_o (meas_step),
    .gt_o        (gt),
    .lt_o        (lt)
  );

  trip_cal_stepper #(.OFS_W(OFS_W)) i_stepper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chk_i     (chk),
    .en_i      (cal_en_i),
    .gt_i      (gt),
    .lt_i      (lt),
    .ofs_min_i (ofs_min_i),
    .ofs_max_i (ofs_max_i),
    .ps_done_i (ps_done_i),
    .accept_o  (accept),
    .ps_step_o (ps_step_o),
    .ps_dir_o  (ps_dir_o),
    .busy_o    (busy_o),
    .ofs_o     (ofs_o),
    .oor_o     (oor_o)
  );

  // status reflects the offset before the step of the same check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      stp_q <= '0;
    end else if (accept) begin
      cyc_q <= meas_cyc;
      stp_q <= meas_step;
    end
  end

  assign cur_cyc_o  = cyc_q;
  assign cur_step_o = stp_q;
endmodule

// File: rtl/trip_cal_chk.sv
module trip_cal_chk #(
  parameter int OFS_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cal_en_i,
  input logic                    auto_chk_i,
  input logic                    chk_req_i,
  input logic                    hf_start_i,
  input logic signed [OFS_W-1:0] ofs_min_i,
  input logic signed [OFS_W-1:0] ofs_max_i,
  input logic                    ps_step_o,
  input logic                    ps_dir_o,
  input logic                    busy_o,
  input logic signed [OFS_W-1:0] ofs_o,
  input logic                    oor_o
);
  localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

  AST_STEP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_step_o |-> $past(cal_en_i)); // R1

  AST_STEP_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_step_o |-> $past(chk_req_i || (auto_chk_i && hf_start_i))); // R3

  AST_OFS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ps_step_o |-> $stable(ofs_o)); // R6

  AST_OFS_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_step_o && ps_dir_o) |-> (ofs_o == $past(ofs_o) + ONE)); // R6

  AST_OFS_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_step_o && !ps_dir_o) |-> (ofs_o == $past(ofs_o) - ONE)); // R6

  AST_STEP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_step_o |=> !ps_step_o); // R7

  AST_STEP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_step_o |-> (busy_o && !$past(busy_o))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_step_o && ps_dir_o) |-> ($past(ofs_o) < $past(ofs_max_i))); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_step_o && !ps_dir_o) |-> ($past(ofs_o) > $past(ofs_min_i))); // R8

  AST_OOR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oor_o) |-> oor_o); // R8
endmodule

bind trip_delay_cal trip_cal_chk #(.OFS_W(OFS_W)) i_trip_cal_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cal_en_i   (cal_en_i),
  .auto_chk_i (auto_chk_i),
  .chk_req_i  (chk_req_i),
  .hf_start_i (hf_start_i),
  .ofs_min_i  (ofs_min_i),
  .ofs_max_i  (ofs_max_i),
  .ps_step_o  (ps_step_o),
  .ps_dir_o   (ps_dir_o),
  .busy_o     (busy_o),
  .ofs_o      (ofs_o),
  .oor_o      (oor_o)
);

// File: tb/test_trip_delay_cal.sv
module test_trip_delay_cal;
  localparam int CYC_W  = 6;
  localparam int SPC    = 8;
  localparam int OFS_W  = 6;
  localparam int BF_W   = 8;
  localparam int WD_W   = 4;
  localparam int STEP_W = $clog2(SPC);
  localparam int DLY_W  = CYC_W + STEP_W;

  typedef struct {
    int    cyc;
    int    stp;
    bit    step;
    bit    dir;
    int    ofs;
    bit    oor;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cal_en = 1'b0, auto_chk = 1'b0, chk_req = 1'b0, hf_start = 1'b0;
  logic [CYC_W-1:0] tgt_cyc = '0;
  logic [STEP_W-1:0] tgt_step = '0;
  logic up_from_reg = 1'b1;
  logic [DLY_W-1:0] up_reg_dly = '0, rx_word = '0, rx_path = '0;
  logic [BF_W-1:0] loc_bf = '0, bf_cnt = '0;
  logic [WD_W-1:0] loc_wd = '0, wd_cnt = '0;
  logic rx_vld = 1'b0, ps_done = 1'b0;
  logic signed [OFS_W-1:0] ofs_min = '0, ofs_max = '0;
  logic ps_step, ps_dir, busy, oor;
  logic [CYC_W-1:0] cur_cyc;
  logic [STEP_W-1:0] cur_step;
  logic signed [OFS_W-1:0] ofs;

  int n_chk = 0, n_fail = 0;
  int up_m = 0, ofs_m = 0;
  bit oor_m = 0, dir_m = 0, last_step = 0;
  exp_t q[$];
  event sampled;

  always #10 clk = ~clk;

  trip_delay_cal #(.CYC_W(CYC_W), .STEPS_PER_CYCLE(SPC), .OFS_W(OFS_W),
                   .BF_W(BF_W), .WD_W(WD_W)) i_trip_delay_cal (
    .clk_i(clk), .rst_ni(rst_ni), .cal_en_i(cal_en), .auto_chk_i(auto_chk),
    .chk_req_i(chk_req), .hf_start_i(hf_start), .tgt_cyc_i(tgt_cyc),
    .tgt_step_i(tgt_step), .up_from_reg_i(up_from_reg), .up_reg_dly_i(up_reg_dly),
    .up_loc_bf_i(loc_bf), .up_loc_wd_i(loc_wd), .bf_cnt_i(bf_cnt), .wd_cnt_i(wd_cnt),
    .rx_vld_i(rx_vld), .rx_word_i(rx_word), .rx_path_dly_i(rx_path),
    .ofs_min_i(ofs_min), .ofs_max_i(ofs_max), .ps_done_i(ps_done),
    .ps_step_o(ps_step), .ps_dir_o(ps_dir), .busy_o(busy), .cur_cyc_o(cur_cyc),
    .cur_step_o(cur_step), .ofs_o(ofs), .oor_o(oor)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // reference model of one accepted check
  task automatic push_exp(input string req);
    exp_t e;
    int meas, tgt;
    meas = up_m + int'(rx_path) + ofs_m;
    if (meas < 0) meas = 0;
    tgt = int'(tgt_cyc) * SPC + int'(tgt_step);
    e.cyc = meas / SPC;
    e.stp = meas % SPC;
    e.step = 0;
    if (cal_en && tgt > meas) begin
      if (ofs_m >= int'(ofs_max)) oor_m = 1;
      else begin ofs_m++; e.step = 1; dir_m = 1; end
    end else if (cal_en && tgt < meas) begin
      if (ofs_m <= int'(ofs_min)) oor_m = 1;
      else begin ofs_m--; e.step = 1; dir_m = 0; end
    end
    e.dir = dir_m;
    e.ofs = ofs_m;
    e.oor = oor_m;
    e.req = req;
    last_step = e.step;
    q.push_back(e);
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      exp_t e;
      @(sampled);
      e = q.pop_front();
      chk_eq({e.req, " step"}, int'(ps_step), int'(e.step));
      if (e.step) chk_eq({e.req, " dir"}, int'(ps_dir), int'(e.dir));
      chk_eq({e.req, " R4 cyc"}, int'(cur_cyc), e.cyc);
      chk_eq({e.req, " R4 stp"}, int'(cur_step), e.stp);
      chk_eq({e.req, " ofs"}, int'(ofs), e.ofs);
      chk_eq({e.req, " R8 oor"}, int'(oor), int'(e.oor));
      chk_eq({e.req, " R7 busy"}, int'(busy), int'(e.step));
    end
  end

  task automatic run_check(input bit via_hf, input bit poke, input string req);
    @(negedge clk);
    push_exp(req);
    if (via_hf) hf_start = 1'b1; else chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
    hf_start = 1'b0;
    -> sampled;
    if (last_step) begin
      if (poke) begin
        int c0, s0, o0;
        c0 = int'(cur_cyc); s0 = int'(cur_step); o0 = int'(ofs);
        tgt_cyc = tgt_cyc + 6'd1;
        chk_req = 1'b1;
        @(negedge clk);
        chk_req = 1'b0;
        @(negedge clk);
        chk_eq("R7 busy-ignored step", int'(ps_step), 0);
        chk_eq("R7 busy-ignored ofs", int'(ofs), o0);
        chk_eq("R7 busy-ignored cyc", int'(cur_cyc), c0);
        chk_eq("R7 busy-ignored stp", int'(cur_step), s0);
        tgt_cyc = tgt_cyc - 6'd1;
      end
      repeat (2) @(negedge clk);
      chk_eq("R7 busy held", int'(busy), 1);
      ps_done = 1'b1;
      @(negedge clk);
      ps_done = 1'b0;
      chk_eq("R7 busy cleared", int'(busy), 0);
    end
  endtask

  task automatic put_word(input int bf, input int wd, input int val, input bit vld);
    @(negedge clk);
    bf_cnt = BF_W'(bf);
    wd_cnt = WD_W'(wd);
    rx_word = DLY_W'(val);
    rx_vld = vld;
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_eq("R9 reset ofs", int'(ofs), 0);
    chk_eq("R9 reset busy", int'(busy), 0);
    chk_eq("R9 reset oor", int'(oor), 0);
    chk_eq("R9 reset cyc", int'(cur_cyc), 0);
    chk_eq("R9 reset step", int'(ps_step), 0);

    up_from_reg = 1'b1; up_reg_dly = 9'd10; up_m = 10;
    rx_path = 9'd20;
    tgt_cyc = 6'd5; tgt_step = 3'd0;
    ofs_min = -6'sd2; ofs_max = 6'sd3;

    run_check(0, 0, "R1 disabled");
    cal_en = 1'b1;
    run_check(0, 1, "R6 up");
    run_check(0, 0, "R6 up");
    run_check(0, 0, "R6 up");
    run_check(0, 0, "R8 max block");

    tgt_cyc = 6'd4; tgt_step = 3'd1;   // 33 steps: equals measurement
    run_check(0, 0, "R2 equal");

    tgt_cyc = 6'd3; tgt_step = 3'd0;   // 24 steps: walk down to min
    for (int i = 0; i < 6; i++) run_check(0, 0, "R8 down");

    auto_chk = 1'b1;
    tgt_cyc = 6'd3; tgt_step = 3'd6;
    run_check(1, 0, "R3 auto");

    auto_chk = 1'b0;
    rx_path = 9'd25;
    @(negedge clk);
    hf_start = 1'b1;
    @(negedge clk);
    hf_start = 1'b0;
    @(negedge clk);
    chk_eq("R3 hf ignored step", int'(ps_step), 0);
    chk_eq("R3 hf ignored cyc", int'(cur_cyc), 3);
    chk_eq("R3 hf ignored stp", int'(cur_step), 4);
    rx_path = 9'd20;

    cal_en = 1'b0;
    up_from_reg = 1'b0;
    loc_bf = 8'd5; loc_wd = 4'd2;
    put_word(5, 1, 50, 1);
    put_word(4, 2, 60, 1);
    put_word(5, 2, 14, 1);
    put_word(5, 2, 99, 0);
    up_m = 14;
    run_check(0, 0, "R5 hyperframe");

    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    ofs_m = 0; oor_m = 0; up_m = 0;
    @(negedge clk);
    chk_eq("R9 mid reset ofs", int'(ofs), 0);
    chk_eq("R9 mid reset oor", int'(oor), 0);
    chk_eq("R9 mid reset cyc", int'(cur_cyc), 0);
    run_check(0, 0, "R9 latch cleared");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule